// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-slave SPI master controlled through a simple 32-bit register bus made of an address, a write strobe, write data and combinational read data. Software sets the word size and the serial clock divisor in a configuration register. It drives the chip select directly through a control bit. Writing a word to the transmit offset starts one mode 0 transfer, with SCK idle low and data sampled on the rising edge.

While the word shifts out on MOSI, most significant bit first, the controller collects MISO into a receive register. When the last bit is done, a completion flag in the cause register goes high. Software polls that flag, reads the received word, and writes the cause offset to clear the flag before it sends the next word.

The serial clock comes from an even divider of the system clock. The prescale field carries the divisor as 0x10 plus half its value. Values outside the legal range are clamped to the nearest legal divisor.

Top module: `spi_regmaster`

## Requirements
- R1: After reset, cs_n is 1, sck is 0 and mosi is 0. The control, configuration, cause and receive offsets all read 0.
- R2: Bit 0 of the control register (offset 0x00) sets cs_n. Writing 1 drives cs_n to 0, and writing 0 drives cs_n to 1.
- R3: The configuration register (offset 0x04) stores and reads back three fields. Bits 4:0 hold the prescale, bit 5 selects the word size and bit 14 is the timing-adjust enable. Every other bit reads 0.
- R4: A write to the transmit offset (0x08) while idle starts a mode 0 transfer. MOSI carries the word most significant bit first and changes only while sck is low. MISO is sampled on each rising sck edge.
- R5: With configuration bit 5 at 0, a transfer gives exactly 8 sck pulses. It sends bits 7:0 of the written word, and the receive offset (0x0C) reads the 8 received bits in bits 7:0 with zeros above.
- R6: With configuration bit 5 at 1, a transfer gives exactly 16 sck pulses. It sends bits 15:0 of the written word, and the receive offset reads the 16 received bits in bits 15:0.
- R7: For a prescale P with bit 4 set and P ≥ 0x12, sck stays high for (P−0x10) system clocks and low for (P−0x10) system clocks in each bit. The divisor is therefore 2·(P−0x10).
- R8: A prescale with bit 4 clear, or equal to 0x10 or 0x11, behaves as divisor 4, which gives 2 clocks high and 2 clocks low.
- R9: After the last bit, the cause offset (0x10) reads 1. Any write to the cause offset clears it to 0. A completion in the same cycle as that write takes priority.
- R10: A write to the transmit offset during a transfer is ignored. The transfer in progress keeps its word, its pulse count and its length.
- R11: Reads of the transmit offset and of any unmapped offset return 0. Writes to unmapped offsets leave every register unchanged.
- R12: Whenever no transfer is in progress, sck and mosi are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench plays an SPI slave that returns a known pattern. It runs a table of words through both word sizes and through prescales that include the clamped values (bit 4 clear, and 0x11). A divider that ignored the clamp would give a zero-length or wrong-length sck phase, and the high-cycle count would show it. A narrow-mode transfer with the wrong bit alignment would either send the upper byte or let stale bits leak into the receive value.

A second transmit write is issued mid-transfer. A design that restarted on it would give extra pulses or a corrupted word at the slave. The cause flag is cleared and read back after each word, and unmapped writes are checked so they cannot disturb the select or the configuration.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Register byte offsets; software relies on these positions.
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_CFG   = 'h04;
  localparam int OFF_TX    = 'h08;
  localparam int OFF_RX    = 'h0C;
  localparam int OFF_CAUSE = 'h10;

  // Configuration field placement.
  localparam int PRE_W         = 5;
  localparam int HALF_W        = PRE_W - 1;
  localparam int CFG_WIDE_BIT  = 5;
  localparam int CFG_TADJ_BIT  = 14;
  localparam int MIN_HALF      = 2;

  typedef struct packed {
    logic             tadj;
    logic             wide;
    logic [PRE_W-1:0] presc;
  } cfg_t;

  // Clamp a prescale code to the legal half-period range (2..15 clocks).
  function automatic logic [HALF_W-1:0] eff_half(input logic [PRE_W-1:0] p);
    logic [HALF_W-1:0] h;
    if (!p[PRE_W-1]) begin
      h = HALF_W'(MIN_HALF);
    end else if (p[HALF_W-1:0] < HALF_W'(MIN_HALF)) begin
      h = HALF_W'(MIN_HALF);
    end else begin
      h = p[HALF_W-1:0];
    end
    return h;
  endfunction

endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);

  logic [HALF_W-1:0] half_q, half_d;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic [HALF_W-1:0] new_half;

  assign new_half = eff_half(presc);

  // Next-state: divisor latched at start, counter reloads every half period.
  always_comb begin
    half_d = half_q;
    cnt_d  = cnt_q;
    if (load) begin
      half_d = new_half;
      cnt_d  = new_half - HALF_W'(1);
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_d = half_q - HALF_W'(1);
      end else begin
        cnt_d = cnt_q - HALF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_W'(MIN_HALF);
      cnt_q  <= '0;
    end else begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
    end
  end

  assign tick = run && !load && (cnt_q == '0);

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int WORD_W = 16,
  localparam int NARROW_W = WORD_W / 2,
  localparam int BIT_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [WORD_W-1:0] rx_word
);

  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic              done_q, done_d;
  logic              wide_q, wide_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic [BIT_W-1:0]  last_bit;
  logic [WORD_W-1:0] load_word;

  assign last_bit = wide_q ? BIT_W'(WORD_W - 1) : BIT_W'(NARROW_W - 1);

  // Narrow words are aligned to the top of the shift register so the
  // output bit is always the register MSB.
  assign load_word = wide ? tx_word
                          : {tx_word[NARROW_W-1:0], {NARROW_W{1'b0}}};

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    done_d = 1'b0;
    wide_d = wide_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      sck_d  = 1'b0;
      wide_d = wide;
      bit_d  = '0;
      tx_d   = load_word;
      rx_d   = '0;
    end else if (busy_q && tick) begin
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[WORD_W-2:0], miso};
      end else begin
        sck_d = 1'b0;
        if (bit_q == last_bit) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + BIT_W'(1);
          tx_d  = {tx_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      wide_q <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      wide_q <= wide_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = busy_q & tx_q[WORD_W-1];
  assign done    = done_q;
  assign rx_word = wide_q ? rx_q : {{NARROW_W{1'b0}}, rx_q[NARROW_W-1:0]};

endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [WORD_W-1:0] rx_word,
  output logic [DATA_W-1:0] rdata,
  output logic              cs,
  output cfg_t              cfg,
  output logic              start,
  output logic [WORD_W-1:0] tx_word,
  output logic              cause
);

  logic              sel_ctrl, sel_cfg, sel_tx, sel_rx, sel_cause;
  logic              cs_q, cs_d;
  cfg_t              cfg_q, cfg_d;
  logic [WORD_W-1:0] rx_q, rx_d;
  logic              cause_q, cause_d;
  logic              unused_wdata_hi;

  assign sel_ctrl  = (addr == ADDR_W'(OFF_CTRL));
  assign sel_cfg   = (addr == ADDR_W'(OFF_CFG));
  assign sel_tx    = (addr == ADDR_W'(OFF_TX));
  assign sel_rx    = (addr == ADDR_W'(OFF_RX));
  assign sel_cause = (addr == ADDR_W'(OFF_CAUSE));

  assign unused_wdata_hi = ^wdata[DATA_W-1:WORD_W];

  always_comb begin
    cs_d    = cs_q;
    cfg_d   = cfg_q;
    rx_d    = rx_q;
    cause_d = cause_q;
    if (wen && sel_ctrl) begin
      cs_d = wdata[0];
    end
    if (wen && sel_cfg) begin
      cfg_d.presc = wdata[PRE_W-1:0];
      cfg_d.wide  = wdata[CFG_WIDE_BIT];
      cfg_d.tadj  = wdata[CFG_TADJ_BIT];
    end
    if (done) begin
      rx_d    = rx_word;
      cause_d = 1'b1;
    end else if (wen && sel_cause) begin
      cause_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      cfg_q   <= '0;
      rx_q    <= '0;
      cause_q <= 1'b0;
    end else begin
      cs_q    <= cs_d;
      cfg_q   <= cfg_d;
      rx_q    <= rx_d;
      cause_q <= cause_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl) begin
      rdata[0] = cs_q;
    end else if (sel_cfg) begin
      rdata[PRE_W-1:0]   = cfg_q.presc;
      rdata[CFG_WIDE_BIT] = cfg_q.wide;
      rdata[CFG_TADJ_BIT] = cfg_q.tadj;
    end else if (sel_rx) begin
      rdata[WORD_W-1:0] = rx_q;
    end else if (sel_cause) begin
      rdata[0] = cause_q;
    end
  end

  assign start   = wen && sel_tx && !busy;
  assign tx_word = wdata[WORD_W-1:0];
  assign cs      = cs_q;
  assign cfg     = cfg_q;
  assign cause   = cause_q;

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spim_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);

  logic              rst_meta_q, rst_sync_n;
  logic              xfer_busy, xfer_done, xfer_start, div_tick;
  logic              cs_level, cause_flag;
  logic [WORD_W-1:0] tx_word, rx_word;
  cfg_t              cfg;

  // Reset asserts immediately and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  spim_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .WORD_W(WORD_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .addr    (bus_addr),
    .wen     (bus_wen),
    .wdata   (bus_wdata),
    .busy    (xfer_busy),
    .done    (xfer_done),
    .rx_word (rx_word),
    .rdata   (bus_rdata),
    .cs      (cs_level),
    .cfg     (cfg),
    .start   (xfer_start),
    .tx_word (tx_word),
    .cause   (cause_flag)
  );

  spim_clkdiv u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (xfer_start),
    .run   (xfer_busy),
    .presc (cfg.presc),
    .tick  (div_tick)
  );

  spim_shifter #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (xfer_start),
    .wide    (cfg.wide),
    .tx_word (tx_word),
    .tick    (div_tick),
    .miso    (miso),
    .busy    (xfer_busy),
    .sck     (sck),
    .mosi    (mosi),
    .done    (xfer_done),
    .rx_word (rx_word)
  );

  assign cs_n = ~cs_level;

endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spim_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck,
  input logic              mosi,
  input logic              cs_n,
  input logic              busy,
  input logic              done,
  input logic              cause,
  input logic              bus_wen,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wdata0
);

  // R12: idle line levels
  a_r12_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !mosi));

  // R4: data held while the clock is high
  a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  // R4: a transfer only ends by completing
  a_r4_end_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9: completion sets the cause flag
  a_r9_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cause);

  // R9: a cause write without completion clears it
  a_r9_cause_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && (bus_addr == ADDR_W'(OFF_CAUSE)) && !done) |=> !cause);

  // R2: control bit 0 sets the select level
  a_r2_cs_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && (bus_addr == ADDR_W'(OFF_CTRL))) |=> (cs_n == !$past(bus_wdata0)));

endmodule

bind spi_regmaster spim_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .sck        (sck),
  .mosi       (mosi),
  .cs_n       (cs_n),
  .busy       (xfer_busy),
  .done       (xfer_done),
  .cause      (cause_flag),
  .bus_wen    (bus_wen),
  .bus_addr   (bus_addr),
  .bus_wdata0 (bus_wdata[0])
);

// File: tb/spi_regmaster_bench.sv
`timescale 1ns/1ps
module spi_regmaster_bench;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_CFG   = 8'h04;
  localparam logic [7:0] A_TX    = 8'h08;
  localparam logic [7:0] A_RX    = 8'h0C;
  localparam logic [7:0] A_CAUSE = 8'h10;

  // {wide, prescale, tx word, slave word, expected half period}
  localparam int NVEC = 6;
  localparam logic [41:0] VEC [NVEC] = '{
    {1'b0, 5'h12, 16'h00A5, 16'h003C, 4'd2},
    {1'b1, 5'h13, 16'h1234, 16'hBEEF, 4'd3},
    {1'b0, 5'h1F, 16'h0081, 16'h007E, 4'd15},
    {1'b1, 5'h05, 16'hF00F, 16'h0FF0, 4'd2},
    {1'b0, 5'h11, 16'h0000, 16'h00FF, 4'd2},
    {1'b1, 5'h17, 16'h8001, 16'h5AA5, 4'd7}
  };

  logic        clk, rst_n, bus_wen, miso, sck, mosi, cs_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0;
  int errors = 0;

  spi_regmaster u_spi_regmaster (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Slave model: shifts mosi in on rising sck, presents miso from a pattern.
  int          rise_cnt = 0;
  int          fall_cnt = 0;
  int          hi_cnt   = 0;
  int          fall_base = 0;
  logic [15:0] slave_rx = '0;
  logic [15:0] slv_pat  = '0;

  always @(posedge sck) begin
    rise_cnt <= rise_cnt + 1;
    slave_rx <= {slave_rx[14:0], mosi};
  end
  always @(negedge sck) fall_cnt <= fall_cnt + 1;
  always @(negedge clk) if (sck) hi_cnt <= hi_cnt + 1;

  always @* begin
    int k;
    k = fall_cnt - fall_base;
    miso = (k >= 0 && k < 16) ? slv_pat[15-k] : 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] d;
    int n;
    n = 0;
    d = '0;
    while (d == 0 && n < 3000) begin
      rd(A_CAUSE, d);
      n++;
    end
    chk(d == 32'h1, tag, d, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", 32'(cs_n), 32'h1);
    chk(sck == 1'b0 && mosi == 1'b0, "R1 sck/mosi", {30'b0, sck, mosi}, 32'h0);
    rd(A_CTRL, d);  chk(d == 0, "R1 ctrl", d, 0);
    rd(A_CFG, d);   chk(d == 0, "R1 cfg", d, 0);
    rd(A_CAUSE, d); chk(d == 0, "R1 cause", d, 0);
    rd(A_RX, d);    chk(d == 0, "R1 rx", d, 0);

    // R3 configuration readback
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, d); chk(d == 32'h0000_403F, "R3 cfg all ones", d, 32'h0000_403F);
    wr(A_CFG, 32'h0000_0000);
    rd(A_CFG, d); chk(d == 0, "R3 cfg zero", d, 0);

    // R2 chip select
    wr(A_CTRL, 32'h1);
    chk(cs_n == 1'b0, "R2 select on", 32'(cs_n), 0);
    rd(A_CTRL, d); chk(d == 1, "R2 ctrl read", d, 1);

    // Vector table: R4..R8, R9, R12
    for (int i = 0; i < NVEC; i++) begin
      logic        vw;
      logic [4:0]  vp;
      logic [15:0] vtx, vsl, exp_rx, exp_tx;
      int          half, nbits, r0, h0;
      vw = VEC[i][41]; vp = VEC[i][40:36]; vtx = VEC[i][35:20];
      vsl = VEC[i][19:4]; half = int'(VEC[i][3:0]);
      nbits  = vw ? 16 : 8;
      exp_rx = vw ? vsl : {8'h00, vsl[7:0]};
      exp_tx = vw ? vtx : {8'h00, vtx[7:0]};
      wr(A_CFG, {26'b0, vw, vp});
      slv_pat   = vw ? vsl : {vsl[7:0], 8'h00};
      fall_base = fall_cnt;
      r0 = rise_cnt; h0 = hi_cnt;
      wr(A_TX, {16'hDEAD, vtx});
      wait_done($sformatf("R9 cause set vec%0d", i));
      chk(rise_cnt - r0 == nbits, $sformatf("%s pulses vec%0d", vw ? "R6" : "R5", i),
          32'(rise_cnt - r0), 32'(nbits));
      chk(hi_cnt - h0 == nbits * half, $sformatf("R7/R8 high clocks vec%0d", i),
          32'(hi_cnt - h0), 32'(nbits * half));
      chk((slave_rx & (vw ? 16'hFFFF : 16'h00FF)) == exp_tx,
          $sformatf("R4 mosi word vec%0d", i),
          32'(slave_rx & (vw ? 16'hFFFF : 16'h00FF)), 32'(exp_tx));
      rd(A_RX, d);
      chk(d == 32'(exp_rx), $sformatf("%s rx vec%0d", vw ? "R6" : "R5", i), d, 32'(exp_rx));
      wr(A_CAUSE, 32'h0);
      rd(A_CAUSE, d); chk(d == 0, $sformatf("R9 cause clear vec%0d", i), d, 0);
      chk(sck == 1'b0 && mosi == 1'b0, $sformatf("R12 idle vec%0d", i),
          {30'b0, sck, mosi}, 0);
    end

    // R10: second transmit write mid-transfer is ignored
    begin
      int r0;
      wr(A_CFG, 32'h0000_0032);
      slv_pat = 16'h9669; fall_base = fall_cnt; r0 = rise_cnt;
      wr(A_TX, 32'h0000_C3A5);
      repeat (10) @(negedge clk);
      wr(A_TX, 32'h0000_5A5A);
      wait_done("R10 done");
      chk(rise_cnt - r0 == 16, "R10 pulses", 32'(rise_cnt - r0), 16);
      chk(slave_rx == 16'hC3A5, "R10 word kept", 32'(slave_rx), 32'hC3A5);
      rd(A_RX, d); chk(d == 32'h9669, "R10 rx", d, 32'h9669);
      wr(A_CAUSE, 32'h0);
    end

    // R11: transmit offset and unmapped offsets
    rd(A_TX, d); chk(d == 0, "R11 tx reads zero", d, 0);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0000_0000);
    rd(8'h14, d); chk(d == 0, "R11 unmapped read", d, 0);
    rd(A_CFG, d); chk(d == 32'h32, "R11 cfg untouched", d, 32'h32);
    rd(A_CTRL, d); chk(d == 1, "R11 ctrl untouched", d, 1);
    chk(cs_n == 1'b0, "R11 select untouched", 32'(cs_n), 0);

    wr(A_CTRL, 32'h0);
    chk(cs_n == 1'b1, "R2 select off", 32'(cs_n), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule